// File: doc/BRIEF.md
# Averaged DC-DC Converter Plant Emulator

This block is a real-time, fixed-point solver for an averaged buck or boost power stage. A hardware-in-the-loop rig uses it in place of a real converter. A digital controller under test supplies a duty command. The block then advances two states, inductor current and capacitor voltage, by one discrete step per simulation tick. The default tick is 625 clocks, which is 5 µs at 125 MHz. The model includes the inductor's series resistance and the switch on-resistance. Within one step the current is updated first, and that fresh current is then used in the voltage update.

The duty command, input voltage, load conductance (1/R) and topology select are captured at each step boundary and held for the whole step. Because of this capture, a duty command arrives on average half a step late. The step reciprocals Ts/L and Ts/C and the two resistances sit in shadow registers. A shadow write reaches the solver only at the next boundary. Both states are available as signed values and as offset-binary DAC codes. A pulse-width output shows the latched duty so it can be viewed on a scope.

Top module: `dcdc_plant_emu`

## Requirements
- R1: A synchronous reset (`rst` high) clears both states, every parameter register, the latched duty and the strobes. While it is held, `iLOut`/`vCOut` read 0, both DAC outputs read 0x8000, and `stateValid` and `pwmOut` are 0.
- R2: A step boundary falls every STEP_CYCLES cycles. The first is the STEP_CYCLES-th cycle after reset is released. `stateValid` is high for exactly one cycle, four cycles after each boundary, and the new pair of states appears in that cycle. Both states stay unchanged between two valid pulses.
- R3: With `topoSel`=0 (buck), new current = iL + kL·(d·Vin − vC − iL·(rL + d·rDs)), using the previous iL and vC.
- R4: In buck, new voltage = vC + kC·(iLnew − vC·G). This uses the current computed in the same step.
- R5: With `topoSel`=1 (boost), new current = iL + kL·(Vin − (1−d)·vC − iL·(rL + d·rDs)).
- R6: In boost, new voltage = vC + kC·((1−d)·iLnew − vC·G).
- R7: All values are signed Q(STATE_W−FRAC_W).FRAC_W (defaults: 16 bits, 12 fractional). Each product is formed at full width, arithmetically shifted right by FRAC_W and clamped to the signed STATE_W range. Each sum or difference is clamped the same way. d = dutyCmd·2^(FRAC_W−DUTY_W), read as a fraction of 1.0 = 2^FRAC_W, and 1−d is formed with a clamped subtraction.
- R8: `dutyCmd`, `vinIn`, `loadG` and `topoSel` are sampled only in the boundary cycle. A change after the boundary leaves that step's result unchanged and is used at the next step.
- R9: A write with `paramWe`=1 loads `paramData` into the shadow register chosen by `paramSel` (0 kL=Ts/L, 1 kC=Ts/C, 2 rL, 3 rDs). The value is used from the first boundary after the write cycle, never inside the step in progress.
- R10: `iLDac` and `vCDac` equal the matching state with its sign bit inverted (state + 2^(STATE_W−1) modulo 2^STATE_W).
- R11: A DUTY_W-bit free-running counter drives `pwmOut`. Over any 2^DUTY_W consecutive cycles with a constant latched duty, `pwmOut` is high for exactly dutyCmd cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| topoSel | input | 1 | 0 buck, 1 boost; sampled at step boundary |
| dutyCmd | input | DUTY_W | Duty command, fraction of 2^DUTY_W |
| vinIn | input | STATE_W | Input voltage, signed Q format |
| loadG | input | STATE_W | Load conductance 1/R, signed Q format |
| paramWe | input | 1 | Shadow parameter write strobe |
| paramSel | input | 2 | Shadow register select (0 kL, 1 kC, 2 rL, 3 rDs) |
| paramData | input | STATE_W | Shadow parameter write data |
| iLOut | output | STATE_W | Inductor current state, signed |
| vCOut | output | STATE_W | Capacitor voltage state, signed |
| iLDac | output | STATE_W | Inductor current, offset-binary DAC code |
| vCDac | output | STATE_W | Capacitor voltage, offset-binary DAC code |
| stateValid | output | 1 | One-cycle pulse when a new state pair is published |
| pwmOut | output | 1 | Pulse-width view of the latched duty |

## Verification
The clamp paths are the hardest part to reach from the ports. With realistic reciprocals the states drift so slowly that neither rail is ever reached. The stimulus therefore loads step reciprocals near 1.0 and opens the load (G = 0). A boost step at zero duty then pushes the voltage into the positive rail within two steps, and a negated input voltage drives it into the negative rail. The capture-only-at-boundary behaviour is reached by using the valid pulse to find the cycle just after a boundary, then changing the inputs or writing a parameter there. The next result must still follow the old values.

// File: rtl/dcdc_plant_pkg.sv
package dcdc_plant_pkg;

  typedef enum logic {
    TOPO_BUCK  = 1'b0,
    TOPO_BOOST = 1'b1
  } topo_e;

  typedef enum logic [1:0] {
    PSEL_KL  = 2'd0,
    PSEL_KC  = 2'd1,
    PSEL_RL  = 2'd2,
    PSEL_RDS = 2'd3
  } paramSel_e;

  // Strobes from sequencer to datapath, one step of the solver.
  typedef struct packed {
    logic latch;    // boundary: capture inputs and shadow parameters
    logic calcCur;  // register the new inductor current
    logic calcVol;  // register the new capacitor voltage
    logic commit;   // publish both states together
  } stepStrobes_t;

endpackage

// File: rtl/plant_ctrl.sv
module plant_ctrl
  import dcdc_plant_pkg::*;
#(
  parameter int STEP_CYCLES = 625
) (
  input  logic         clk,
  input  logic         rst,
  output stepStrobes_t strobes
);

  localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] stepCnt;
  logic [2:0]       phasePipe;
  logic             atBoundary;

  assign atBoundary = (stepCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      stepCnt   <= '0;
      phasePipe <= '0;
    end else begin
      if (atBoundary) stepCnt <= '0;
      else            stepCnt <= stepCnt + 1'b1;
      phasePipe <= {phasePipe[1:0], atBoundary};
    end
  end

  assign strobes.latch   = atBoundary;
  assign strobes.calcCur = phasePipe[0];
  assign strobes.calcVol = phasePipe[1];
  assign strobes.commit  = phasePipe[2];

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.latch, strobes.calcCur, strobes.calcVol, strobes.commit})); // R2

  AST_BOUNDARY_SPACING: assert property (@(posedge clk) disable iff (rst)
    strobes.latch |=> !strobes.latch); // R2

endmodule

// File: rtl/plant_datapath.sv
module plant_datapath
  import dcdc_plant_pkg::*;
#(
  parameter int STATE_W = 16,
  parameter int FRAC_W  = 12,
  parameter int DUTY_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  stepStrobes_t              strobes,
  input  logic                      topoSel,
  input  logic [DUTY_W-1:0]         dutyCmd,
  input  logic signed [STATE_W-1:0] vinIn,
  input  logic signed [STATE_W-1:0] loadG,
  input  logic                      paramWe,
  input  logic [1:0]                paramSel,
  input  logic signed [STATE_W-1:0] paramData,
  output logic signed [STATE_W-1:0] iLState,
  output logic signed [STATE_W-1:0] vCState,
  output logic                      stateValid,
  output logic                      pwmOut
);

  localparam int W      = STATE_W;
  localparam int WIDE   = 2 * STATE_W;
  localparam int DSHIFT = FRAC_W - DUTY_W;
  localparam int ONE_INT = 1 << FRAC_W;
  localparam logic signed [W-1:0] ONE_Q = W'(ONE_INT);

  // ---------------- saturating fixed-point helpers ----------------
  function automatic logic signed [W-1:0] satQ(input logic signed [WIDE-1:0] x);
    logic [W:0] upper;
    upper = x[WIDE-1:W-1];
    if (upper == '0 || upper == '1) return x[W-1:0];
    else if (x[WIDE-1])             return {1'b1, {(W-1){1'b0}}};
    else                            return {1'b0, {(W-1){1'b1}}};
  endfunction

  function automatic logic signed [WIDE-1:0] widen(input logic signed [W-1:0] a);
    return {{W{a[W-1]}}, a};
  endfunction

  function automatic logic signed [W-1:0] mulQ(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] b);
    logic signed [WIDE-1:0] prod;
    prod = widen(a) * widen(b);
    return satQ(prod >>> FRAC_W);
  endfunction

  function automatic logic signed [W-1:0] addQ(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] b);
    return satQ(widen(a) + widen(b));
  endfunction

  function automatic logic signed [W-1:0] subQ(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] b);
    return satQ(widen(a) - widen(b));
  endfunction

  // ---------------- registers ----------------
  logic signed [W-1:0] kLShadow, kCShadow, rLShadow, rDsShadow;
  logic signed [W-1:0] kLAct, kCAct, rLAct, rDsAct;
  logic [DUTY_W-1:0]   dutyLat;
  logic signed [W-1:0] vinLat, gLat;
  logic                topoLat;
  logic signed [W-1:0] iLReg, vCReg, iLNext, vCNext;
  logic                validReg;
  logic [DUTY_W-1:0]   pwmCnt;

  // ---------------- combinational solver ----------------
  logic signed [W-1:0] dQ, omQ, rEff, dropV, driveV, iLCalc, srcI, loadI, vCCalc;

  assign dQ  = $signed({{(W-DUTY_W){1'b0}}, dutyLat} << DSHIFT);
  assign omQ = subQ(ONE_Q, dQ);

  // phase 1: new inductor current from previous states
  always_comb begin
    rEff  = addQ(rLAct, mulQ(dQ, rDsAct));
    dropV = mulQ(iLReg, rEff);
    if (topoLat == TOPO_BOOST) driveV = subQ(vinLat, mulQ(omQ, vCReg));
    else                       driveV = subQ(mulQ(dQ, vinLat), vCReg);
    iLCalc = addQ(iLReg, mulQ(kLAct, subQ(driveV, dropV)));
  end

  // phase 2: new capacitor voltage from the fresh current
  always_comb begin
    if (topoLat == TOPO_BOOST) srcI = mulQ(omQ, iLNext);
    else                       srcI = iLNext;
    loadI  = mulQ(vCReg, gLat);
    vCCalc = addQ(vCReg, mulQ(kCAct, subQ(srcI, loadI)));
  end

  // ---------------- sequential ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      kLShadow  <= '0; kCShadow <= '0; rLShadow <= '0; rDsShadow <= '0;
      kLAct     <= '0; kCAct    <= '0; rLAct    <= '0; rDsAct    <= '0;
      dutyLat   <= '0; vinLat   <= '0; gLat     <= '0; topoLat   <= 1'b0;
      iLReg     <= '0; vCReg    <= '0; iLNext   <= '0; vCNext    <= '0;
      validReg  <= 1'b0;
      pwmCnt    <= '0;
    end else begin
      if (paramWe) begin
        case (paramSel_e'(paramSel))
          PSEL_KL:  kLShadow  <= paramData;
          PSEL_KC:  kCShadow  <= paramData;
          PSEL_RL:  rLShadow  <= paramData;
          PSEL_RDS: rDsShadow <= paramData;
          default:  ;
        endcase
      end
      if (strobes.latch) begin
        kLAct   <= kLShadow;
        kCAct   <= kCShadow;
        rLAct   <= rLShadow;
        rDsAct  <= rDsShadow;
        dutyLat <= dutyCmd;
        vinLat  <= vinIn;
        gLat    <= loadG;
        topoLat <= topoSel;
      end
      if (strobes.calcCur) iLNext <= iLCalc;
      if (strobes.calcVol) vCNext <= vCCalc;
      if (strobes.commit) begin
        iLReg <= iLNext;
        vCReg <= vCNext;
      end
      validReg <= strobes.commit;
      pwmCnt   <= pwmCnt + 1'b1;
    end
  end

  assign iLState    = iLReg;
  assign vCState    = vCReg;
  assign stateValid = validReg;
  assign pwmOut     = (pwmCnt < dutyLat);

  AST_STATES_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !strobes.commit |=> ($stable(iLReg) && $stable(vCReg))); // R2

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stateValid |=> !stateValid); // R2

  AST_INPUTS_HELD: assert property (@(posedge clk) disable iff (rst)
    !strobes.latch |=> $stable({dutyLat, vinLat, gLat, topoLat})); // R8

  AST_PARAMS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !strobes.latch |=> $stable({kLAct, kCAct, rLAct, rDsAct})); // R9

  AST_CUR_BEFORE_VOL: assert property (@(posedge clk) disable iff (rst)
    strobes.calcVol |-> $past(strobes.calcCur)); // R4

endmodule

// File: rtl/dcdc_plant_emu.sv
module dcdc_plant_emu
  import dcdc_plant_pkg::*;
#(
  parameter int STATE_W     = 16,
  parameter int FRAC_W      = 12,
  parameter int DUTY_W      = 8,
  parameter int STEP_CYCLES = 625
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      topoSel,
  input  logic [DUTY_W-1:0]         dutyCmd,
  input  logic signed [STATE_W-1:0] vinIn,
  input  logic signed [STATE_W-1:0] loadG,
  input  logic                      paramWe,
  input  logic [1:0]                paramSel,
  input  logic signed [STATE_W-1:0] paramData,
  output logic signed [STATE_W-1:0] iLOut,
  output logic signed [STATE_W-1:0] vCOut,
  output logic [STATE_W-1:0]        iLDac,
  output logic [STATE_W-1:0]        vCDac,
  output logic                      stateValid,
  output logic                      pwmOut
);

  stepStrobes_t strobes;

  plant_ctrl #(
    .STEP_CYCLES(STEP_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes)
  );

  plant_datapath #(
    .STATE_W (STATE_W),
    .FRAC_W  (FRAC_W),
    .DUTY_W  (DUTY_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .topoSel    (topoSel),
    .dutyCmd    (dutyCmd),
    .vinIn      (vinIn),
    .loadG      (loadG),
    .paramWe    (paramWe),
    .paramSel   (paramSel),
    .paramData  (paramData),
    .iLState    (iLOut),
    .vCState    (vCOut),
    .stateValid (stateValid),
    .pwmOut     (pwmOut)
  );

  // offset-binary codes for a unipolar DAC
  assign iLDac = {~iLOut[STATE_W-1], iLOut[STATE_W-2:0]};
  assign vCDac = {~vCOut[STATE_W-1], vCOut[STATE_W-2:0]};

endmodule

// File: tb/sim_dcdc_plant_emu.sv
`timescale 1ns/1ps
module sim_dcdc_plant_emu;

  localparam int STEP = 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               topoSel = 1'b0;
  logic [7:0]         dutyCmd = '0;
  logic signed [15:0] vinIn = '0;
  logic signed [15:0] loadG = '0;
  logic               paramWe = 1'b0;
  logic [1:0]         paramSel = '0;
  logic signed [15:0] paramData = '0;
  logic signed [15:0] iLOut, vCOut;
  logic [15:0]        iLDac, vCDac;
  logic               stateValid, pwmOut;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  // model state and active parameters
  int mIL = 0, mVC = 0;
  int mKL = 0, mKC = 0, mRL = 0, mRDs = 0;

  always #4 clk = ~clk;

  dcdc_plant_emu #(.STEP_CYCLES(STEP)) u0 (
    .clk(clk), .rst(rst), .topoSel(topoSel), .dutyCmd(dutyCmd),
    .vinIn(vinIn), .loadG(loadG), .paramWe(paramWe), .paramSel(paramSel),
    .paramData(paramData), .iLOut(iLOut), .vCOut(vCOut), .iLDac(iLDac),
    .vCDac(vCDac), .stateValid(stateValid), .pwmOut(pwmOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog act=%0d exp<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  function automatic int satI(longint x);
    if (x > 32767)  return 32767;
    if (x < -32768) return -32768;
    return int'(x);
  endfunction
  function automatic int mulI(int a, int b);
    longint p;
    p = longint'(a) * longint'(b);
    return satI(p >>> 12);
  endfunction
  function automatic int addI(int a, int b); return satI(longint'(a) + longint'(b)); endfunction
  function automatic int subI(int a, int b); return satI(longint'(a) - longint'(b)); endfunction

  task automatic modelStep(input int topo, input int duty, input int vin, input int g);
    int dq, om, rEff, drop, drive, nIL, src, nVC;
    dq    = duty * 16;
    om    = subI(4096, dq);
    rEff  = addI(mRL, mulI(dq, mRDs));
    drop  = mulI(mIL, rEff);
    drive = (topo != 0) ? subI(vin, mulI(om, mVC)) : subI(mulI(dq, vin), mVC);
    nIL   = addI(mIL, mulI(mKL, subI(drive, drop)));
    src   = (topo != 0) ? mulI(om, nIL) : nIL;
    nVC   = addI(mVC, mulI(mKC, subI(src, mulI(mVC, g))));
    mIL = nIL;
    mVC = nVC;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic waitValid();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!stateValid && n < 4 * STEP);
    if (!stateValid) begin
      nFail++;
      $display("FAIL R2 valid timeout act=%0d exp<%0d", n, 4 * STEP);
    end
  endtask

  task automatic writeParam(input int sel, input int val);
    @(negedge clk);
    paramWe = 1'b1; paramSel = 2'(sel); paramData = 16'(val);
    @(negedge clk);
    paramWe = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 iL reset", int'(iLOut), 0);
    chk("R1 vC reset", int'(vCOut), 0);
    chk("R1 iL dac reset", int'(iLDac), 32768);
    chk("R1 vC dac reset", int'(vCDac), 32768);
    chk("R1 valid reset", int'(stateValid), 0);
    chk("R1 pwm reset", int'(pwmOut), 0);
    rst = 1'b0;
    mIL = 0; mVC = 0; mKL = 0; mKC = 0; mRL = 0; mRDs = 0;
  endtask

  // drive inputs, wait for the step that latches them, compare with model
  task automatic doStep(input int topo, input int duty, input int vin, input int g,
                        input string tagI, input string tagV);
    topoSel = topo[0]; dutyCmd = 8'(duty); vinIn = 16'(vin); loadG = 16'(g);
    waitValid();
    modelStep(topo, duty, vin, g);
    chk(tagI, int'(iLOut), mIL);
    chk(tagV, int'(vCOut), mVC);
  endtask

  task automatic loadParams(input int kl, input int kc, input int rl, input int rds);
    writeParam(0, kl); writeParam(1, kc); writeParam(2, rl); writeParam(3, rds);
    mKL = kl; mKC = kc; mRL = rl; mRDs = rds;
  endtask

  initial begin
    int dutyList[5] = '{0, 51, 128, 204, 255};
    int extreme;
    int held, gap, snapI, snapV, changed, highCnt;

    doReset();                                   // R1
    loadParams(205, 82, 205, 82);

    // sweep both topologies over several duties
    for (int topo = 0; topo < 2; topo++) begin
      for (int di = 0; di < 5; di++) begin
        for (int s = 0; s < 6; s++) begin
          if (topo == 0) doStep(0, dutyList[di], 20480, 2048, "R3 buck iL", "R4 buck vC");
          else           doStep(1, dutyList[di], 20480, 2048, "R5 boost iL", "R6 boost vC");
          chk("R10 iL dac", int'(iLDac), (mIL + 32768) & 16'hFFFF);
          chk("R10 vC dac", int'(vCDac), (mVC + 32768) & 16'hFFFF);
        end
      end
    end

    // R2: pulse width, spacing and held states
    waitValid();
    modelStep(1, 255, 20480, 2048);
    snapI = int'(iLOut); snapV = int'(vCOut);
    chk("R2 iL at valid", snapI, mIL);
    gap = 0; changed = 0; held = 0;
    do begin
      @(negedge clk);
      gap++;
      if (gap == 1) held = int'(stateValid);
      if (!stateValid && (int'(iLOut) != snapI || int'(vCOut) != snapV)) changed = 1;
    end while (!stateValid && gap < 4 * STEP);
    modelStep(1, 255, 20480, 2048);
    chk("R2 valid width", held, 0);
    chk("R2 valid spacing", gap, STEP);
    chk("R2 states held", changed, 0);
    chk("R2 next iL", int'(iLOut), mIL);

    // R8: inputs changed just after a boundary do not affect that step
    doStep(0, 100, 20480, 2048, "R3 buck iL", "R4 buck vC");
    repeat (STEP - 3) @(negedge clk);            // first cycle after boundary
    topoSel = 1'b1; dutyCmd = 8'd30; vinIn = 16'sd12288; loadG = 16'sd4096;
    waitValid();
    modelStep(0, 100, 20480, 2048);
    chk("R8 old inputs iL", int'(iLOut), mIL);
    chk("R8 old inputs vC", int'(vCOut), mVC);
    waitValid();
    modelStep(1, 30, 12288, 4096);
    chk("R8 new inputs iL", int'(iLOut), mIL);
    chk("R8 new inputs vC", int'(vCOut), mVC);

    // R9: parameter write during a step waits for next boundary
    doStep(0, 180, 20480, 2048, "R3 buck iL", "R4 buck vC");
    repeat (STEP - 3) @(negedge clk);
    paramWe = 1'b1; paramSel = 2'd0; paramData = 16'sd1000;
    @(negedge clk);
    paramWe = 1'b0;
    waitValid();
    modelStep(0, 180, 20480, 2048);
    chk("R9 old kL iL", int'(iLOut), mIL);
    chk("R9 old kL vC", int'(vCOut), mVC);
    mKL = 1000;
    waitValid();
    modelStep(0, 180, 20480, 2048);
    chk("R9 new kL iL", int'(iLOut), mIL);
    chk("R9 new kL vC", int'(vCOut), mVC);

    // R11: pulse-width output over a full counter period
    foreach (dutyList[i]) begin
      if (i == 1) continue;
      dutyCmd = 8'(dutyList[i]);
      waitValid();
      waitValid();
      highCnt = 0;
      for (int c = 0; c < 256; c++) begin
        @(negedge clk);
        if (pwmOut) highCnt++;
      end
      chk("R11 pwm high count", highCnt, dutyList[i]);
    end
    dutyCmd = 8'd77;
    waitValid(); waitValid();
    highCnt = 0;
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      if (pwmOut) highCnt++;
    end
    chk("R11 pwm high count 77", highCnt, 77);

    // R7: positive rail, boost, open load, near-unity reciprocals
    doReset();                                   // R1 after activity
    loadParams(4095, 4095, 205, 82);
    extreme = 0;
    for (int s = 0; s < 4; s++) begin
      doStep(1, 0, 20480, 0, "R7 sat iL", "R7 sat vC");
      if (int'(vCOut) > extreme) extreme = int'(vCOut);
    end
    chk("R7 positive clamp", extreme, 32767);

    // R7: negative rail
    doReset();
    loadParams(4095, 4095, 205, 82);
    extreme = 0;
    for (int s = 0; s < 4; s++) begin
      doStep(1, 0, -20480, 0, "R7 sat iL", "R7 sat vC");
      if (int'(vCOut) < extreme) extreme = int'(vCOut);
    end
    chk("R7 negative clamp", extreme, -32768);
    chk("R10 vC dac at rail", int'(vCDac), (mVC + 32768) & 16'hFFFF);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule